// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block runs whole I2C transactions on top of a byte-level, status-coded I2C master. One command selects a probe, a register read or a register write. It also carries a 7-bit chip address, zero to four sub-address bytes and a payload length. The sequencer writes control values and bytes to the master. After each write it waits for the master's interrupt flag and compares the reported status code with the code that step should produce.

Write payload bytes arrive on a valid/ready input port, and read bytes leave on a valid/ready output port. A read that has a sub-address sends the sub-address in write mode first. It then turns the bus around with a repeated START and no STOP in between. Every transaction ends with a STOP, including one that failed part-way.

The block returns a 32-bit result word. The word is zero on success. On failure it holds an error class, the last control value written, the status that was seen and the status that was expected. Each wait is bounded by a count of SCL-period ticks.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset `busy`, `res_valid` and `m_ctrl_we` are low and `cmd_ready` is high.
- R2: `cmd_op` 2 (write) sends, in this order: START, the chip address shifted left with bit 0 = 0, the sub-address bytes from index `cmd_sublen-1` down to index 0 (byte i is `cmd_sub[8i+7:8i]`), and then `cmd_len` payload bytes. Each byte after the address expects status 0x28.
- R3: `cmd_op` 1 (read) with `cmd_sublen` > 0 sends the write-mode address and the sub-address bytes. It then issues a repeated START that expects status 0x10, with no STOP before it. With `cmd_sublen` = 0 the first START is the read START, and every first START expects 0x08.
- R4: Each received byte is requested with control 0x44 (enable plus ACK, bit 2), except the last, which uses 0x40 (NAK). The expected statuses are 0x50 and 0x58.
- R5: `cmd_op` 0 (probe) sends START and the read address, receives exactly one byte with NAK, discards it, and then stops. A present chip gives result 0.
- R6: The status expected after an address byte comes from its R/W bit: 0x40 for a read and 0x18 for a write.
- R7: Error word layout: bits 31:24 hold the class (1 = wrong status, 2 = timeout), bits 23:16 the last control value written, bits 15:8 the status observed and bits 7:0 the expected status. Control values are enable 0x40, START 0x20, STOP 0x10 and ACK 0x04. The byte sends use 0x40, START uses 0x60 and STOP uses 0x50.
- R8: A wait that sees no interrupt flag within `POLL_LIMIT` `scl_tick` pulses ends with class 2.
- R9: After a wrong status or a timeout, no further byte or START is issued. Exactly one STOP (0x50) follows in every transaction.
- R10: After the STOP the block polls for status 0xF8. A STOP timeout gives class 2 with expected 0xF8, but only when no earlier error was recorded. Otherwise the first error is returned.
- R11: `busy` rises on the cycle after a command is accepted and stays high through a single-cycle `res_valid` pulse.
- R12: Read bytes are delivered in bus order on `rd_data`. Each is held stable while `rd_valid` is high and `rd_ready` is low. Write bytes are taken only when `wr_valid` and `wr_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_tick | input | 1 | One pulse per SCL period, used for wait timeouts |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when a command can be accepted |
| cmd_op | input | 2 | 0 probe, 1 read, 2 write |
| cmd_chip | input | 7 | 7-bit chip address |
| cmd_sub | input | 8*SUB_MAX | Sub-address bytes, byte i at bits 8i+7:8i |
| cmd_sublen | input | SUBN_W | Number of sub-address bytes, 0 to SUB_MAX |
| cmd_len | input | LEN_W | Number of payload bytes |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle if valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer accepts the read byte |
| rd_data | output | 8 | Read byte |
| m_ctrl_we | output | 1 | Control write strobe to the master |
| m_ctrl | output | 8 | Control value written |
| m_wdata | output | 8 | Byte to transmit, valid with the strobe |
| m_iflg | input | 1 | Master step-complete flag |
| m_status | input | 8 | Master status code |
| m_rdata | input | 8 | Byte received by the master |
| busy | output | 1 | Transaction in progress |
| res_valid | output | 1 | Result word valid, one cycle |
| res_word | output | 32 | Zero on success, error word otherwise |

## Verification
The assertions assume the master model clears its interrupt flag once it sees a control write. They also assume the read consumer lowers `rd_ready` only between handshakes, and that commands carry `cmd_sublen` no larger than `SUB_MAX` and an opcode of 0, 1 or 2. The bench's master model follows exactly that contract. Its random delays, its NAK and hang injection and its random ready and valid gaps all stay inside these limits. The same holds for the random commands, which draw only legal opcodes and lengths.

// File: rtl/i2c_txn_pkg.sv
package i2c_txn_pkg;
    localparam logic [7:0] CTL_ACK   = 8'h04;
    localparam logic [7:0] CTL_STOP  = 8'h10;
    localparam logic [7:0] CTL_START = 8'h20;
    localparam logic [7:0] CTL_EN    = 8'h40;

    localparam logic [7:0] ST_FIRST  = 8'h08;
    localparam logic [7:0] ST_AGAIN  = 8'h10;
    localparam logic [7:0] ST_AW_ACK = 8'h18;
    localparam logic [7:0] ST_DW_ACK = 8'h28;
    localparam logic [7:0] ST_AR_ACK = 8'h40;
    localparam logic [7:0] ST_DR_ACK = 8'h50;
    localparam logic [7:0] ST_DR_NAK = 8'h58;
    localparam logic [7:0] ST_IDLE   = 8'hF8;

    localparam logic [7:0] CLS_STATUS  = 8'h01;
    localparam logic [7:0] CLS_TIMEOUT = 8'h02;

    typedef enum logic [1:0] {OP_PROBE = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2} op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_WAIT, S_RDOUT, S_STOP, S_SWAIT, S_DONE
    } state_e;

    typedef enum logic [2:0] {
        PH_STARTW, PH_ADDRW, PH_SUB, PH_WDATA, PH_STARTR, PH_ADDRR, PH_RECV
    } phase_e;

    function automatic logic [31:0] pack_err(logic [7:0] cls, logic [7:0] ctl,
                                             logic [7:0] seen, logic [7:0] want);
        return {cls, ctl, seen, want};
    endfunction
endpackage

// File: rtl/i2c_txn_timer.sv
module i2c_txn_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = !clr && tick && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
    import i2c_txn_pkg::*;
#(
    parameter int SUB_MAX    = 4,
    parameter int LEN_W      = 8,
    parameter int POLL_LIMIT = 1000,
    localparam int SUBN_W    = $clog2(SUB_MAX + 1),
    localparam int SUB_W     = 8 * SUB_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_tick,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [6:0]        cmd_chip,
    input  logic [SUB_W-1:0]  cmd_sub,
    input  logic [SUBN_W-1:0] cmd_sublen,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              m_ctrl_we,
    output logic [7:0]        m_ctrl,
    output logic [7:0]        m_wdata,
    input  logic              m_iflg,
    input  logic [7:0]        m_status,
    input  logic [7:0]        m_rdata,
    output logic              busy,
    output logic              res_valid,
    output logic [31:0]       res_word
);
    typedef struct packed {
        state_e            state;
        phase_e            phase;
        logic [1:0]        op;
        logic [6:0]        chip;
        logic [SUB_W-1:0]  sub;
        logic [SUBN_W-1:0] sub_left;
        logic [LEN_W-1:0]  len_left;
        logic              started;
        logic [7:0]        exp;
        logic [7:0]        ctl_last;
        logic [31:0]       err;
        logic [7:0]        rbyte;
    } seq_t;

    seq_t d, q;

    logic              tmr_clr, tmr_exp;
    logic              is_write, is_read, go;
    logic [7:0]        ctl_v, dat_v, exp_v;
    logic [SUBN_W-1:0] sub_idx;
    phase_e            post_sub_ph;
    logic              post_sub_stop;

    i2c_txn_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick   (scl_tick),
        .expired(tmr_exp)
    );

    assign is_write      = (q.op == OP_WRITE);
    assign is_read       = (q.op == OP_READ);
    assign sub_idx       = q.sub_left - 1'b1;
    assign post_sub_ph   = is_write ? PH_WDATA : PH_STARTR;
    assign post_sub_stop = is_write && (q.len_left == '0);

    always_comb begin
        d         = q;
        tmr_clr   = !((q.state == S_WAIT) || (q.state == S_SWAIT));
        m_ctrl_we = 1'b0;
        ctl_v     = CTL_EN;
        dat_v     = 8'h00;
        exp_v     = q.exp;
        go        = 1'b1;
        wr_ready  = 1'b0;
        rd_valid  = 1'b0;
        res_valid = 1'b0;

        unique case (q.state)
            S_IDLE: begin
                if (cmd_valid) begin
                    d.op       = cmd_op;
                    d.chip     = cmd_chip;
                    d.sub      = cmd_sub;
                    d.sub_left = cmd_sublen;
                    d.len_left = (cmd_op == OP_PROBE || cmd_op == 2'd3) ? LEN_W'(1) : cmd_len;
                    d.started  = 1'b0;
                    d.err      = '0;
                    d.phase    = (cmd_op == OP_WRITE || (cmd_op == OP_READ && cmd_sublen != '0))
                                 ? PH_STARTW : PH_STARTR;
                    d.state    = S_ISSUE;
                end
            end
            S_ISSUE: begin
                unique case (q.phase)
                    PH_STARTW, PH_STARTR: begin
                        ctl_v = CTL_EN | CTL_START;
                        exp_v = q.started ? ST_AGAIN : ST_FIRST;
                    end
                    PH_ADDRW: begin dat_v = {q.chip, 1'b0}; exp_v = ST_AW_ACK; end
                    PH_ADDRR: begin dat_v = {q.chip, 1'b1}; exp_v = ST_AR_ACK; end
                    PH_SUB: begin
                        dat_v = q.sub[8*sub_idx +: 8];
                        exp_v = ST_DW_ACK;
                    end
                    PH_WDATA: begin
                        wr_ready = 1'b1;
                        go       = wr_valid;
                        dat_v    = wr_data;
                        exp_v    = ST_DW_ACK;
                    end
                    PH_RECV: begin
                        if (is_read && q.len_left > LEN_W'(1)) begin
                            ctl_v = CTL_EN | CTL_ACK;
                            exp_v = ST_DR_ACK;
                        end else begin
                            exp_v = ST_DR_NAK;
                        end
                    end
                    default: go = 1'b0;
                endcase
                if (go) begin
                    m_ctrl_we  = 1'b1;
                    d.ctl_last = ctl_v;
                    d.exp      = exp_v;
                    d.state    = S_WAIT;
                    if (q.phase == PH_STARTW || q.phase == PH_STARTR) d.started = 1'b1;
                end
            end
            S_WAIT: begin
                if (m_iflg) begin
                    if (m_status == q.exp) begin
                        d.state = S_ISSUE;
                        unique case (q.phase)
                            PH_STARTW: d.phase = PH_ADDRW;
                            PH_STARTR: d.phase = PH_ADDRR;
                            PH_ADDRW: begin
                                if (q.sub_left != '0) d.phase = PH_SUB;
                                else if (post_sub_stop) d.state = S_STOP;
                                else d.phase = post_sub_ph;
                            end
                            PH_SUB: begin
                                d.sub_left = q.sub_left - 1'b1;
                                if (q.sub_left != SUBN_W'(1)) d.phase = PH_SUB;
                                else if (post_sub_stop) d.state = S_STOP;
                                else d.phase = post_sub_ph;
                            end
                            PH_WDATA: begin
                                d.len_left = q.len_left - 1'b1;
                                if (q.len_left == LEN_W'(1)) d.state = S_STOP;
                            end
                            PH_ADDRR: begin
                                if (q.len_left == '0) d.state = S_STOP;
                                else d.phase = PH_RECV;
                            end
                            PH_RECV: begin
                                if (is_read) begin
                                    d.rbyte = m_rdata;
                                    d.state = S_RDOUT;
                                end else begin
                                    d.state = S_STOP;
                                end
                            end
                            default: d.state = S_STOP;
                        endcase
                    end else begin
                        d.err   = pack_err(CLS_STATUS, q.ctl_last, m_status, q.exp);
                        d.state = S_STOP;
                    end
                end else if (tmr_exp) begin
                    d.err   = pack_err(CLS_TIMEOUT, q.ctl_last, m_status, q.exp);
                    d.state = S_STOP;
                end
            end
            S_RDOUT: begin
                rd_valid = 1'b1;
                if (rd_ready) begin
                    d.len_left = q.len_left - 1'b1;
                    d.phase    = PH_RECV;
                    d.state    = (q.len_left == LEN_W'(1)) ? S_STOP : S_ISSUE;
                end
            end
            S_STOP: begin
                m_ctrl_we  = 1'b1;
                ctl_v      = CTL_EN | CTL_STOP;
                d.ctl_last = CTL_EN | CTL_STOP;
                d.state    = S_SWAIT;
            end
            S_SWAIT: begin
                if (m_status == ST_IDLE) begin
                    d.state = S_DONE;
                end else if (tmr_exp) begin
                    if (q.err == '0)
                        d.err = pack_err(CLS_TIMEOUT, q.ctl_last, m_status, ST_IDLE);
                    d.state = S_DONE;
                end
            end
            S_DONE: begin
                res_valid = 1'b1;
                d.state   = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.phase <= PH_STARTW;
        end else begin
            q <= d;
        end
    end

    assign m_ctrl    = ctl_v;
    assign m_wdata   = dat_v;
    assign rd_data   = q.rbyte;
    assign res_word  = q.err;
    assign busy      = (q.state != S_IDLE);
    assign cmd_ready = (q.state == S_IDLE);
endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        busy,
    input logic        res_valid,
    input logic [31:0] res_word,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [7:0]  rd_data,
    input logic        m_ctrl_we,
    input logic        wr_ready
);
    assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy |=> busy);
    assert_res_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    assert_res_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);
    assert_err_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_word != 32'h0 |-> res_word[31:24] == 8'h01 || res_word[31:24] == 8'h02);
    assert_single_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_ctrl_we |=> !m_ctrl_we);
    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
    assert_wr_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> busy);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_ctrl_we && !rd_valid);
endmodule

bind i2c_txn_seq i2c_txn_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .busy     (busy),
    .res_valid(res_valid),
    .res_word (res_word),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .m_ctrl_we(m_ctrl_we),
    .wr_ready (wr_ready)
);

// File: tb/tb_i2c_txn_seq.sv
`timescale 1ns/1ps
module tb_i2c_txn_seq;
    localparam int SUB_MAX = 4;
    localparam int LEN_W   = 8;
    localparam int PLIM    = 6;
    localparam int SUBN_W  = $clog2(SUB_MAX + 1);

    logic clk = 1'b0, rst_n = 1'b0, scl_tick = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready;
    logic [1:0] cmd_op = '0;
    logic [6:0] cmd_chip = '0;
    logic [8*SUB_MAX-1:0] cmd_sub = '0;
    logic [SUBN_W-1:0] cmd_sublen = '0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic wr_valid = 1'b0, wr_ready;
    logic [7:0] wr_data = '0;
    logic rd_valid, rd_ready = 1'b0;
    logic [7:0] rd_data;
    logic m_ctrl_we;
    logic [7:0] m_ctrl, m_wdata;
    logic m_iflg = 1'b0;
    logic [7:0] m_status = 8'hF8, m_rdata = '0;
    logic busy, res_valid;
    logic [31:0] res_word;

    always #2.5 clk = ~clk;

    i2c_txn_seq #(.SUB_MAX(SUB_MAX), .LEN_W(LEN_W), .POLL_LIMIT(PLIM)) dut (
        .clk(clk), .rst_n(rst_n), .scl_tick(scl_tick),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_chip(cmd_chip), .cmd_sub(cmd_sub), .cmd_sublen(cmd_sublen),
        .cmd_len(cmd_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .m_ctrl_we(m_ctrl_we), .m_ctrl(m_ctrl),
        .m_wdata(m_wdata), .m_iflg(m_iflg), .m_status(m_status),
        .m_rdata(m_rdata), .busy(busy), .res_valid(res_valid),
        .res_word(res_word));

    int checks = 0, errors = 0;

    // model configuration and logs
    int nak_at = -1, hang_at = -1;
    bit stop_hang = 0;
    bit in_txn = 0, after_start = 0, reading = 0;
    int pend = 0, stop_pend = 0, send_idx = 0, tick_div = 0;
    logic [7:0] pend_st = '0, pend_rd = '0;
    logic [7:0] sent [16];
    int sent_n = 0, starts = 0, stops = 0;
    bit ack_log [16];
    int ack_n = 0;
    logic [7:0] sup [16];
    int sup_n = 0;
    logic [7:0] got [16];
    int got_n = 0;
    logic [7:0] wdat [16];
    int wr_idx = 0, wr_len = 0;
    bit res_seen = 0;
    logic [31:0] res_got = '0;

    // prediction
    logic [7:0] e_bytes [16];
    int e_n = 0, e_idx = 0, e_rd = 0;
    bit e_ack [16];
    int e_ack_n = 0;
    logic [31:0] e_res = '0;
    logic [7:0] e_last = 8'hF8;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void pred_send(logic [7:0] b, bit is_addr, logic [7:0] want);
        if (e_res != 0) return;
        e_bytes[e_n] = b; e_n++;
        if (e_idx == nak_at)
            e_res = {8'h01, 8'h40, is_addr ? (b[0] ? 8'h48 : 8'h20) : 8'h30, want};
        else if (e_idx == hang_at)
            e_res = {8'h02, 8'h40, 8'hF8, want};
        else
            e_last = is_addr ? (b[0] ? 8'h40 : 8'h18) : 8'h28;
        e_idx++;
    endfunction

    function automatic void predict(int op, logic [6:0] chip, logic [31:0] sub, int sl, int len);
        e_n = 0; e_idx = 0; e_rd = 0; e_ack_n = 0; e_res = 0; e_last = 8'hF8;
        if (op == 2 || (op == 1 && sl > 0)) begin
            e_last = 8'h08;
            pred_send({chip, 1'b0}, 1, 8'h18);
            for (int i = sl - 1; i >= 0; i--) pred_send(sub[8*i +: 8], 0, 8'h28);
        end
        if (op == 2) begin
            for (int i = 0; i < len; i++) pred_send(wdat[i], 0, 8'h28);
        end else begin
            if (e_res == 0) e_last = (op == 1 && sl > 0) ? 8'h10 : 8'h08;
            pred_send({chip, 1'b1}, 1, 8'h40);
            if (op == 0) begin
                if (e_res == 0) begin e_ack[0] = 0; e_ack_n = 1; e_last = 8'h58; end
            end else begin
                for (int i = 0; i < len; i++) begin
                    if (e_res == 0) begin
                        e_ack[e_ack_n] = (i < len - 1); e_ack_n++; e_rd++;
                        e_last = (i < len - 1) ? 8'h50 : 8'h58;
                    end
                end
            end
        end
        if (e_res == 0 && stop_hang) e_res = {8'h02, 8'h50, e_last, 8'hF8};
    endfunction

    // bus-side model, stream feeders and observers: all act after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            tick_div = (tick_div + 1) % 4;
            scl_tick = (tick_div == 0);
            rd_ready = ($urandom % 3) != 0;
            wr_valid = (wr_idx < wr_len) && (($urandom % 3) != 0);
            wr_data  = wdat[wr_idx % 16];
            #1;
            if (rd_valid && rd_ready) begin got[got_n % 16] = rd_data; got_n++; end
            if (wr_valid && wr_ready) wr_idx++;
            if (res_valid) begin res_seen = 1; res_got = res_word; end
            if (m_ctrl_we) begin
                m_iflg = 1'b0;
                if (m_ctrl[5]) begin
                    starts++; pend_st = in_txn ? 8'h10 : 8'h08;
                    in_txn = 1; after_start = 1; reading = 0; pend = 1 + $urandom % 5;
                end else if (m_ctrl[4]) begin
                    stops++; in_txn = 0; reading = 0; pend = 0;
                    stop_pend = stop_hang ? 0 : 1 + $urandom % 5;
                end else if (reading) begin
                    ack_log[ack_n % 16] = m_ctrl[2]; ack_n++;
                    pend_rd = 8'($urandom); sup[sup_n % 16] = pend_rd; sup_n++;
                    pend_st = m_ctrl[2] ? 8'h50 : 8'h58; pend = 1 + $urandom % 5;
                end else begin
                    sent[sent_n % 16] = m_wdata; sent_n++;
                    if (send_idx == nak_at) begin
                        pend_st = after_start ? (m_wdata[0] ? 8'h48 : 8'h20) : 8'h30;
                        pend = 1 + $urandom % 5;
                    end else if (send_idx == hang_at) begin
                        m_status = 8'hF8; pend = 0;
                    end else begin
                        pend_st = after_start ? (m_wdata[0] ? 8'h40 : 8'h18) : 8'h28;
                        if (after_start && m_wdata[0]) reading = 1;
                        pend = 1 + $urandom % 5;
                    end
                    after_start = 0; send_idx++;
                end
            end else begin
                if (pend > 0) begin
                    pend--;
                    if (pend == 0) begin m_iflg = 1'b1; m_status = pend_st; m_rdata = pend_rd; end
                end
                if (stop_pend > 0) begin
                    stop_pend--;
                    if (stop_pend == 0) m_status = 8'hF8;
                end
            end
        end
    end

    task automatic run_txn(input int op, input logic [6:0] chip, input logic [31:0] sub,
                           input int sl, input int len, input int nk, input int hg,
                           input bit sh, input string tag);
        nak_at = nk; hang_at = hg; stop_hang = sh;
        sent_n = 0; starts = 0; stops = 0; ack_n = 0; sup_n = 0; got_n = 0;
        send_idx = 0; wr_idx = 0; res_seen = 0;
        for (int i = 0; i < 16; i++) wdat[i] = 8'($urandom);
        wr_len = (op == 2) ? len : 0;
        predict(op, chip, sub, sl, len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_chip = chip; cmd_sub = sub;
        cmd_sublen = SUBN_W'(sl); cmd_len = LEN_W'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1.5;
        chk("R11 busy after accept", {31'b0, busy}, 32'd1);
        for (int c = 0; c < 3000 && !res_seen; c++) @(negedge clk);
        #2;
        chk({tag, " result"}, res_got, e_res);
        chk("R9 one STOP", stops, 1);
        chk("R2/R9 bytes sent", sent_n, e_n);
        for (int i = 0; i < e_n && i < sent_n; i++)
            chk("R2 byte order", {24'b0, sent[i]}, {24'b0, e_bytes[i]});
        chk("R4 recv count", ack_n, e_ack_n);
        for (int i = 0; i < e_ack_n && i < ack_n; i++)
            chk("R4 ack pattern", {31'b0, ack_log[i]}, {31'b0, e_ack[i]});
        chk("R12 read bytes delivered", got_n, e_rd);
        for (int i = 0; i < e_rd && i < got_n; i++)
            chk("R12 read data", {24'b0, got[i]}, {24'b0, sup[i]});
        wr_len = 0;
        @(negedge clk);
        #1.5;
        chk("R11 idle after result", {31'b0, busy}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy reset", {31'b0, busy}, 32'd0);
        chk("R1 res_valid reset", {31'b0, res_valid}, 32'd0);
        chk("R1 ctrl_we reset", {31'b0, m_ctrl_we}, 32'd0);
        chk("R1 cmd_ready reset", {31'b0, cmd_ready}, 32'd1);
        rst_n = 1'b1;
        // R2 write with two sub-address bytes, high index first
        run_txn(2, 7'h50, 32'h0000_A1B2, 2, 3, -1, -1, 0, "R2 write");
        // R3 read with sub-address uses repeated START (0x10)
        run_txn(1, 7'h51, 32'h0000_00C3, 1, 3, -1, -1, 0, "R3 read sub");
        // R3 read without sub-address starts with 0x08
        run_txn(1, 7'h22, 32'h0, 0, 1, -1, -1, 0, "R3 read nosub");
        // R5 probe of a present chip
        run_txn(0, 7'h3C, 32'h0, 0, 0, -1, -1, 0, "R5 probe ok");
        // R6/R7 probe of an absent chip: {01,40,48,40}
        run_txn(0, 7'h3D, 32'h0, 0, 0, 0, -1, 0, "R6 probe absent");
        // R6/R7 write to absent chip: {01,40,20,18}
        run_txn(2, 7'h11, 32'h0000_0055, 1, 2, 0, -1, 0, "R6 write absent");
        // R9 data NAK in the middle aborts the payload
        run_txn(2, 7'h12, 32'h0, 0, 5, 2, -1, 0, "R9 data nak");
        // R8 hang on a sub-address byte gives timeout class
        run_txn(1, 7'h13, 32'h1122_3344, 4, 2, -1, 2, 0, "R8 hang");
        // R10 STOP never completes after a clean write
        run_txn(2, 7'h14, 32'h0, 0, 1, -1, -1, 1, "R10 stop hang");
        // R10 earlier error wins over STOP timeout
        run_txn(2, 7'h15, 32'h0, 0, 2, 1, -1, 1, "R10 first error kept");
        // R3 read of zero bytes after four sub-address bytes
        run_txn(1, 7'h16, 32'hDEAD_BEEF, 4, 0, -1, -1, 0, "R3 read zero len");
        for (int t = 0; t < 40; t++) begin
            int op, sl, len, nk, hg;
            bit sh;
            op  = $urandom % 3;
            sl  = $urandom % (SUB_MAX + 1);
            len = $urandom % 7;
            nk  = (($urandom % 4) == 0) ? int'($urandom % 8) : -1;
            hg  = (nk < 0 && ($urandom % 5) == 0) ? int'($urandom % 8) : -1;
            sh  = ($urandom % 10) == 0;
            run_txn(op, 7'($urandom), $urandom, sl, len, nk, hg, sh, "R7 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule